// File: doc/BRIEF.md
# Register Result Status and Tag-Based Operand Read

This block keeps the architectural floating-point register values together with a per-register producer tag. A tag of zero means the register holds its final value. A nonzero tag names the reservation station whose result will next be written into that register. An issue stage reads two source registers through the block. For each source it gets either a usable value with tag zero or the tag of the pending producer, so the operand is renamed at issue.

In the same cycle the issue stage names the destination register and the station tag of the new instruction. The block records that tag as the destination's producer. Results come back on a broadcast bus that carries data and the producing station's tag, not a register number. Every register whose recorded tag equals the broadcast tag takes the data and returns to tag zero.

A register whose tag was overwritten by a younger instruction ignores the older producer's broadcast. Write-after-write and write-after-read hazards therefore resolve without stalls. Same-cycle interactions are defined: reads bypass a broadcast, and the recorded tag of a new issue wins over the clear of a broadcast.

Top module: `rs_regstat`

## Requirements
- R1: After reset every register reads as value 0 with tag 0.
- R2: A source read of a register whose tag is 0 returns its stored value with tag 0 in the same cycle, whether or not iss_vld is high.
- R3: A source read of a register with a nonzero tag that does not match an active broadcast returns that tag.
- R4: When iss_vld is high, the destination's tag becomes iss_tag from the next cycle. Source reads in the issue cycle see the tag from before that update.
- R5: An active broadcast (bc_vld high) writes bc_data into every register whose tag equals bc_tag and sets their tags to 0 from the next cycle.
- R6: A register whose tag differs from bc_tag, or any register while bc_vld is low, keeps its value and tag. This covers a register whose tag was overwritten by a later issue.
- R7: If a source read hits a register whose tag matches an active broadcast in the same cycle, the read returns bc_data with tag 0.
- R8: If issue names a destination in the same cycle that a matching broadcast clears its tag, the tag becomes iss_tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | Issue valid: record destination tag |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Station tag of the issuing instruction (nonzero) |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| bc_vld | input | 1 | Result broadcast valid |
| bc_tag | input | 4 | Tag of the broadcasting station (nonzero) |
| bc_data | input | 64 | Broadcast result value |
| opa_val | output | 64 | First source value (meaningful when opa_tag is 0) |
| opa_tag | output | 4 | First source producer tag, 0 when the value is ready |
| opb_val | output | 64 | Second source value (meaningful when opb_tag is 0) |
| opb_tag | output | 4 | Second source producer tag, 0 when the value is ready |

## Verification
The assertions assume that iss_tag is nonzero whenever iss_vld is high and that bc_tag is nonzero whenever bc_vld is high. Tag zero is the "ready" encoding and never names a producer. The bench draws every issue and broadcast tag from 1 to 15. Broadcast tags mostly come from tags currently recorded in the registers, so that matches, stale producers and same-cycle bypasses all occur often.

// File: rtl/rs_regstat_pkg.sv
package rs_regstat_pkg;
    localparam int unsigned NREG_DEF   = 16;
    localparam int unsigned DATA_W_DEF = 64;
    localparam int unsigned TAG_W_DEF  = 4;
    localparam int unsigned NPORT      = 2;
endpackage

// File: rtl/rs_store.sv
module rs_store
    import rs_regstat_pkg::*;
#(
    parameter int unsigned NREG   = NREG_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned TAG_W  = TAG_W_DEF,
    localparam int unsigned AW    = $clog2(NREG)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          iss_vld,
    input  logic [AW-1:0]                 iss_dst,
    input  logic [TAG_W-1:0]              iss_tag,
    input  logic                          bc_vld,
    input  logic [TAG_W-1:0]              bc_tag,
    input  logic [DATA_W-1:0]             bc_data,
    output logic [NREG-1:0][DATA_W-1:0]   val_o,
    output logic [NREG-1:0][TAG_W-1:0]    stat_o
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] val;
        logic [NREG-1:0][TAG_W-1:0]  stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            // tag match: capture result and mark ready
            if (bc_vld && (st_q.stat[i] != '0) && (st_q.stat[i] == bc_tag)) begin
                st_d.val[i]  = bc_data;
                st_d.stat[i] = '0;
            end
            // a new producer overrides any clear in the same cycle
            if (iss_vld && (iss_dst == AW'(i))) begin
                st_d.stat[i] = iss_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o  = st_q.val;
    assign stat_o = st_q.stat;
endmodule

// File: rtl/rs_rdport.sv
module rs_rdport
    import rs_regstat_pkg::*;
#(
    parameter int unsigned NREG   = NREG_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned TAG_W  = TAG_W_DEF,
    localparam int unsigned AW    = $clog2(NREG)
) (
    input  logic [NREG-1:0][DATA_W-1:0] val_q,
    input  logic [NREG-1:0][TAG_W-1:0]  stat_q,
    input  logic [AW-1:0]               idx,
    input  logic                        bc_vld,
    input  logic [TAG_W-1:0]            bc_tag,
    input  logic [DATA_W-1:0]           bc_data,
    output logic [DATA_W-1:0]           val,
    output logic [TAG_W-1:0]            tag
);
    logic [TAG_W-1:0] cur_tag;
    logic             byp;

    always_comb begin
        cur_tag = stat_q[idx];
        byp     = bc_vld && (cur_tag != '0) && (cur_tag == bc_tag);
        if (byp) begin
            val = bc_data;
            tag = '0;
        end else begin
            val = val_q[idx];
            tag = cur_tag;
        end
    end
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat
    import rs_regstat_pkg::*;
#(
    parameter int unsigned NREG   = NREG_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned TAG_W  = TAG_W_DEF,
    localparam int unsigned AW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_vld,
    input  logic [AW-1:0]     iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [AW-1:0]     iss_src_a,
    input  logic [AW-1:0]     iss_src_b,
    input  logic              bc_vld,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic [DATA_W-1:0] opa_val,
    output logic [TAG_W-1:0]  opa_tag,
    output logic [DATA_W-1:0] opb_val,
    output logic [TAG_W-1:0]  opb_tag
);
    logic [NREG-1:0][DATA_W-1:0]  val_q;
    logic [NREG-1:0][TAG_W-1:0]   stat_q;
    logic [NPORT-1:0][AW-1:0]     src_idx;
    logic [NPORT-1:0][DATA_W-1:0] rd_val;
    logic [NPORT-1:0][TAG_W-1:0]  rd_tag;

    rs_store #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .iss_vld (iss_vld),
        .iss_dst (iss_dst),
        .iss_tag (iss_tag),
        .bc_vld  (bc_vld),
        .bc_tag  (bc_tag),
        .bc_data (bc_data),
        .val_o   (val_q),
        .stat_o  (stat_q)
    );

    assign src_idx = {iss_src_b, iss_src_a};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rs_rdport #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd (
            .val_q   (val_q),
            .stat_q  (stat_q),
            .idx     (src_idx[p]),
            .bc_vld  (bc_vld),
            .bc_tag  (bc_tag),
            .bc_data (bc_data),
            .val     (rd_val[p]),
            .tag     (rd_tag[p])
        );
    end

    assign opa_val = rd_val[0];
    assign opa_tag = rd_tag[0];
    assign opb_val = rd_val[1];
    assign opb_tag = rd_tag[1];
endmodule

// File: rtl/rs_regstat_chk.sv
module rs_regstat_chk #(
    parameter int unsigned NREG   = 16,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 4,
    localparam int unsigned AW    = $clog2(NREG)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        iss_vld,
    input logic [AW-1:0]               iss_dst,
    input logic [TAG_W-1:0]            iss_tag,
    input logic [AW-1:0]               iss_src_a,
    input logic [AW-1:0]               iss_src_b,
    input logic                        bc_vld,
    input logic [TAG_W-1:0]            bc_tag,
    input logic [DATA_W-1:0]           bc_data,
    input logic [DATA_W-1:0]           opa_val,
    input logic [TAG_W-1:0]            opa_tag,
    input logic [DATA_W-1:0]           opb_val,
    input logic [TAG_W-1:0]            opb_tag,
    input logic [NREG-1:0][DATA_W-1:0] val_q,
    input logic [NREG-1:0][TAG_W-1:0]  stat_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (stat_q == '0)); // R1

    AST_ISSUE_TAG_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> (iss_tag != '0)); // R4

    AST_ISSUE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |=> (stat_q[$past(iss_dst)] == $past(iss_tag))); // R4

    AST_READ_A_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[iss_src_a] != '0) && !(bc_vld && bc_tag == stat_q[iss_src_a])
        |-> (opa_tag == stat_q[iss_src_a])); // R3

    AST_READ_A_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[iss_src_a] == '0) |-> (opa_tag == '0) && (opa_val == val_q[iss_src_a])); // R2

    AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        bc_vld && (bc_tag != '0) && (stat_q[iss_src_a] == bc_tag)
        |-> (opa_tag == '0) && (opa_val == bc_data)); // R7

    AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rst_n)
        bc_vld && (bc_tag != '0) && (stat_q[iss_src_b] == bc_tag)
        |-> (opb_tag == '0) && (opb_val == bc_data)); // R7

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        AST_BCAST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            bc_vld && (bc_tag != '0) && (stat_q[i] == bc_tag)
            |=> (val_q[i] == $past(bc_data))); // R5

        AST_BCAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            bc_vld && (bc_tag != '0) && (stat_q[i] == bc_tag) && !(iss_vld && iss_dst == AW'(i))
            |=> (stat_q[i] == '0)); // R5

        AST_ISSUE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            bc_vld && (stat_q[i] == bc_tag) && iss_vld && (iss_dst == AW'(i))
            |=> (stat_q[i] == $past(iss_tag))); // R8

        AST_NO_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(bc_vld && (bc_tag != '0) && (stat_q[i] == bc_tag))
            |=> $stable(val_q[i])); // R6
    end
endmodule

bind rs_regstat rs_regstat_chk #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_vld   (iss_vld),
    .iss_dst   (iss_dst),
    .iss_tag   (iss_tag),
    .iss_src_a (iss_src_a),
    .iss_src_b (iss_src_b),
    .bc_vld    (bc_vld),
    .bc_tag    (bc_tag),
    .bc_data   (bc_data),
    .opa_val   (opa_val),
    .opa_tag   (opa_tag),
    .opb_val   (opb_val),
    .opb_tag   (opb_tag),
    .val_q     (val_q),
    .stat_q    (stat_q)
);

// File: tb/sim_rs_regstat.sv
`timescale 1ns/1ps
module sim_rs_regstat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_vld = 1'b0;
    logic [3:0]  iss_dst = '0;
    logic [3:0]  iss_tag = '0;
    logic [3:0]  iss_src_a = '0;
    logic [3:0]  iss_src_b = '0;
    logic        bc_vld = 1'b0;
    logic [3:0]  bc_tag = '0;
    logic [63:0] bc_data = '0;
    logic [63:0] opa_val, opb_val;
    logic [3:0]  opa_tag, opb_tag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] m_val [16];
    logic [3:0]  m_tag [16];

    always #4 clk = ~clk;

    rs_regstat u0 (
        .clk(clk), .rst_n(rst_n),
        .iss_vld(iss_vld), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .bc_vld(bc_vld), .bc_tag(bc_tag), .bc_data(bc_data),
        .opa_val(opa_val), .opa_tag(opa_tag), .opb_val(opb_val), .opb_tag(opb_tag)
    );

    task automatic check_port(input string lbl, input string pn, input int s,
                              input logic [63:0] av, input logic [3:0] at);
        logic [3:0]  mt;
        logic [63:0] ev;
        logic [3:0]  et;
        bit          hit;
        bit          cmp_val;
        string       req;
        mt  = m_tag[s];
        hit = bc_vld && (mt != 0) && (mt == bc_tag);
        if (hit) begin
            ev = bc_data; et = 4'd0; cmp_val = 1'b1; req = "R7";
        end else if (mt != 0) begin
            ev = 64'd0; et = mt; cmp_val = 1'b0; req = "R3";
        end else begin
            ev = m_val[s]; et = 4'd0; cmp_val = 1'b1; req = "R2";
        end
        if (lbl != "") req = lbl;
        checks++;
        if (at !== et || (cmp_val && av !== ev)) begin
            failures++;
            $display("FAIL %s port %s reg %0d: actual val=%h tag=%0d expected val=%h tag=%0d",
                     req, pn, s, av, at, ev, et);
        end
    endtask

    task automatic step(input string lbl, input bit iv, input int d, input int t,
                        input int sa, input int sb, input bit bv, input int bt,
                        input logic [63:0] bd);
        @(negedge clk);
        iss_vld = iv; iss_dst = 4'(d); iss_tag = 4'(t);
        iss_src_a = 4'(sa); iss_src_b = 4'(sb);
        bc_vld = bv; bc_tag = 4'(bt); bc_data = bd;
        #1;
        check_port(lbl, "A", sa, opa_val, opa_tag);
        check_port(lbl, "B", sb, opb_val, opb_tag);
        @(posedge clk);
        for (int i = 0; i < 16; i++) begin
            if (bv && m_tag[i] != 0 && m_tag[i] == 4'(bt)) begin
                m_val[i] = bd;
                m_tag[i] = 4'd0;
            end
            if (iv && d == i) m_tag[i] = 4'(t);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_val[i] = '0;
            m_tag[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every register
        for (int i = 0; i < 8; i++) step("R1", 0, 0, 0, 2*i, 2*i+1, 0, 0, 64'd0);

        // R4: issue r3 tag 5; same-cycle read sees old state
        step("R4", 1, 3, 5, 3, 3, 0, 0, 64'd0);
        step("R4", 1, 7, 5, 3, 7, 0, 0, 64'd0);
        // R7: broadcast tag 5 bypasses to both reads
        step("R7", 0, 0, 0, 3, 7, 1, 5, 64'hA5A5_0000_1111_2222);
        // R5: both registers captured the value, tags cleared
        step("R5", 0, 0, 0, 3, 7, 0, 0, 64'd0);

        // R6: stale producer after overwrite
        step("", 1, 4, 2, 0, 1, 0, 0, 64'd0);
        step("", 1, 4, 3, 4, 4, 0, 0, 64'd0);
        step("R6", 0, 0, 0, 4, 3, 1, 2, 64'hDEAD_BEEF_0000_0001);
        step("R6", 0, 0, 0, 4, 3, 1, 3, 64'h0123_4567_89AB_CDEF);
        step("R5", 0, 0, 0, 4, 3, 0, 0, 64'd0);

        // R6: matching tag with bc_vld low is ignored
        step("", 1, 6, 9, 0, 0, 0, 0, 64'd0);
        step("R6", 0, 0, 0, 6, 6, 0, 9, 64'hFFFF_0000_FFFF_0000);
        step("R6", 0, 0, 0, 6, 6, 0, 0, 64'd0);

        // R8: issue beats clear in the same cycle
        step("", 1, 5, 6, 0, 0, 0, 0, 64'd0);
        step("", 1, 5, 7, 1, 2, 1, 6, 64'h1111_2222_3333_4444);
        step("R8", 0, 0, 0, 5, 5, 0, 0, 64'd0);
        step("R7", 0, 0, 0, 5, 0, 1, 7, 64'h5555_6666_7777_8888);
        step("R5", 0, 0, 0, 5, 5, 0, 0, 64'd0);

        // random mix: labels derived per read (R2/R3/R7)
        void'($urandom(32'd2718));
        for (int n = 0; n < 4000; n++) begin
            bit          iv, bv;
            int          d, t, sa, sb, bt, pick;
            logic [63:0] bd;
            iv = ($urandom % 100) < 60;
            d  = $urandom % 16;
            t  = 1 + ($urandom % 15);
            sa = $urandom % 16;
            sb = $urandom % 16;
            bv = ($urandom % 100) < 55;
            pick = $urandom % 16;
            if (m_tag[pick] != 0 && ($urandom % 4) != 0) bt = m_tag[pick];
            else bt = 1 + ($urandom % 15);
            bd = {$urandom, $urandom};
            step("", iv, d, t, sa, sb, bv, bt, bd);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule